// File: doc/BRIEF.md
# Page Write Buffer with Top-Region Write Protect

This block sits behind the serial protocol engine of a byte-addressed non-volatile memory. It gathers the data bytes of one write transfer into a one-row latch. It decides at the stop condition whether those bytes are committed. When they are, it runs a self-timed programming cycle and then writes the bytes into an internal array. The array is erased to all ones at power-up. The protocol engine supplies the loaded address, each received data byte, a level that marks the bit slot right after a data-byte acknowledge, and start and stop pulses. The block also takes the raw write-control pin and answers read requests from the same address counter.

A row holds `2**COL_W` bytes (32 by default). During a write only the low `COL_W` address bits advance, so a long transfer wraps inside the row. Each row position carries a valid bit, so only the positions that received data are written. When the write-control pin is high at any point between the start pulse and the address load, the rows in the top region of the array are left unchanged. The top region is the top quarter by default. The transfer is still acknowledged and the busy timer still runs. With `ADDR_W = 13` the array is 8192 x 8. The default is a smaller array.

Top module: `row_commit_store`

## Requirements
- R1: After reset, `busy_o` is 0 and `rd_data_o` is 00h, and every array location reads FFh.
- R2: A single data byte followed by a stop while `ack_slot_i` is high is stored at the loaded address once the programming cycle has finished.
- R3: Successive data bytes go to successive positions of one row: only address bits `[COL_W-1:0]` increment. A byte past the row end wraps to position 0 and replaces the earlier value there. Row positions that received no byte keep their old contents.
- R4: A stop with `ack_slot_i` low, or a repeated start before the stop, discards the pending bytes. No programming cycle starts and the array is unchanged.
- R5: When the write-control input is high across the qualification window, rows whose top `PROT_MSBS` address bits are all ones (600h to 7FFh by default) are not modified. A write below that region still lands.
- R6: The qualification window runs from the start pulse up to and including the cycle of `addr_load_i`. A high level on any single cycle inside it protects the transfer. A high level that first appears after the address load does not.
- R7: Each accepted `rd_req_i` returns the byte at the current address on `rd_data_o` one clock later and advances the full address, wrapping from the last location to 0. The result does not depend on the write-control input. `rd_data_o` holds its value when no read is accepted.
- R8: `busy_o` rises on the clock after a committing stop and stays high for exactly `WR_CYCLES + 1` cycles. While it is high, start, address, data, stop and read requests are ignored.
- R9: A stop in the acknowledge slot with no data bytes received (an address-only transfer) starts no programming cycle.
- R10: A committing write aimed at a protected row still runs the full busy period, even though no byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or repeated-start pulse from the protocol engine |
| addr_load_i | input | 1 | Pulse: second address byte received, `addr_i` valid |
| addr_i | input | ADDR_W | Byte address loaded with `addr_load_i` |
| byte_vld_i | input | 1 | Pulse: one write data byte received |
| byte_i | input | 8 | Received data byte |
| ack_slot_i | input | 1 | High during the bit slot right after a data-byte acknowledge |
| stop_i | input | 1 | Stop condition pulse |
| wc_i | input | 1 | Write-control pin, high protects the top region |
| rd_req_i | input | 1 | Pulse: fetch the byte at the current address |
| busy_o | output | 1 | Programming cycle in progress |
| rd_data_o | output | 8 | Read data, registered |

## Verification
A read result is due one clock after the edge that accepts `rd_req_i`. The scoreboard pushes the expected byte when the request is driven and pops it on the falling edge that follows the accepting rising edge. `busy_o` is due on the first falling edge after the stop is sampled. The bench then counts high falling edges and expects `WR_CYCLES + 1`. Array contents are checked only after `busy_o` has dropped, because the commit happens in the last busy cycle. Requests applied during busy are checked at the next falling edge by comparing `rd_data_o` with its held value. A current-address read afterwards confirms that the address was not moved.

// File: rtl/rcs_pkg.sv
`timescale 1ns/1ps
package rcs_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef enum logic [1:0] {PG_IDLE, PG_RUN, PG_DONE} pg_state_e;
endpackage

// File: rtl/rcs_wp_qual.sv
`timescale 1ns/1ps
// Qualifies the write-control pin over the window from start to address load.
module rcs_wp_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic start_ev,
   input  logic addr_ev,
   input  logic wc,
   output logic prot_o
);
   logic win_q;
   logic prot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= 1'b0;
         prot_q <= 1'b0;
      end else if (start_ev) begin
         win_q  <= 1'b1;
         prot_q <= wc;
      end else if (win_q) begin
         prot_q <= prot_q | wc;
         if (addr_ev) win_q <= 1'b0;
      end
   end

   assign prot_o = prot_q;
endmodule

// File: rtl/rcs_row_latch.sv
`timescale 1ns/1ps
// Address counter plus one-row data latch with per-position valid mask.
module rcs_row_latch #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned COL_W  = 5
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               start_ev,
   input  logic                               addr_ev,
   input  logic [ADDR_W-1:0]                  addr_i,
   input  logic                               byte_ev,
   input  rcs_pkg::byte_t                     byte_i,
   input  logic                               rd_ev,
   input  logic                               clear,
   output logic [ADDR_W-1:0]                  addr_o,
   output rcs_pkg::byte_t [(1<<COL_W)-1:0]    data_o,
   output logic [(1<<COL_W)-1:0]              mask_o
);
   localparam int unsigned ROW_BYTES = 1 << COL_W;

   logic [ADDR_W-1:0]               addr_q;
   rcs_pkg::byte_t [ROW_BYTES-1:0]  data_q;
   logic [ROW_BYTES-1:0]            mask_q;
   logic [COL_W-1:0]                col;

   assign col = addr_q[COL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (addr_ev) begin
         addr_q <= addr_i;
      end else if (byte_ev) begin
         addr_q[COL_W-1:0] <= col + 1'b1;
      end else if (rd_ev) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         mask_q <= '0;
      end else if (start_ev || clear) begin
         mask_q <= '0;
      end else if (byte_ev) begin
         for (int p = 0; p < ROW_BYTES; p++) begin
            if (col == COL_W'(p)) begin
               data_q[p] <= byte_i;
               mask_q[p] <= 1'b1;
            end
         end
      end
   end

   assign addr_o = addr_q;
   assign data_o = data_q;
   assign mask_o = mask_q;
endmodule

// File: rtl/rcs_prog_timer.sv
`timescale 1ns/1ps
// Self-timed programming cycle: busy for WR_CYCLES+1 cycles, fire in the last count.
module rcs_prog_timer #(
   parameter int unsigned WR_CYCLES = 1250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy_o,
   output logic fire_o
);
   localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

   rcs_pkg::pg_state_e state_q;
   logic [CNT_W-1:0]   cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= rcs_pkg::PG_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            rcs_pkg::PG_IDLE: begin
               cnt_q <= '0;
               if (go) state_q <= rcs_pkg::PG_RUN;
            end
            rcs_pkg::PG_RUN: begin
               if (cnt_q == LAST) state_q <= rcs_pkg::PG_DONE;
               else               cnt_q   <= cnt_q + 1'b1;
            end
            default: state_q <= rcs_pkg::PG_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != rcs_pkg::PG_IDLE);
   assign fire_o = (state_q == rcs_pkg::PG_RUN) && (cnt_q == LAST);
endmodule

// File: rtl/rcs_array.sv
`timescale 1ns/1ps
// Storage array: whole-row masked write port, single registered read port.
module rcs_array #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned COL_W  = 5,
   parameter logic [7:0]  ERASED = 8'hFF
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [ADDR_W-COL_W-1:0]            wr_row,
   input  rcs_pkg::byte_t [(1<<COL_W)-1:0]    wr_data,
   input  logic [(1<<COL_W)-1:0]              wr_mask,
   input  logic                               rd_en,
   input  logic [ADDR_W-1:0]                  rd_addr,
   output rcs_pkg::byte_t                     rd_data
);
   localparam int unsigned DEPTH     = 1 << ADDR_W;
   localparam int unsigned ROW_BYTES = 1 << COL_W;

   rcs_pkg::byte_t mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
      end else if (wr_en) begin
         for (int p = 0; p < ROW_BYTES; p++) begin
            if (wr_mask[p]) mem[{wr_row, COL_W'(p)}] <= wr_data[p];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/row_commit_store.sv
`timescale 1ns/1ps
module row_commit_store #(
   parameter int unsigned ADDR_W    = 11,
   parameter int unsigned COL_W     = 5,
   parameter int unsigned PROT_MSBS = 2,
   parameter int unsigned WR_CYCLES = 1250000,
   parameter logic [7:0]  ERASED    = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              addr_load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              byte_vld_i,
   input  logic [7:0]        byte_i,
   input  logic              ack_slot_i,
   input  logic              stop_i,
   input  logic              wc_i,
   input  logic              rd_req_i,
   output logic              busy_o,
   output logic [7:0]        rd_data_o
);
   localparam int unsigned ROW_BYTES = 1 << COL_W;
   localparam int unsigned ROW_W     = ADDR_W - COL_W;

   if (COL_W < 1 || COL_W >= ADDR_W) begin : g_bad_col
      $error("COL_W must lie in 1..ADDR_W-1");
   end
   if (PROT_MSBS > ROW_W) begin : g_bad_prot
      $error("PROT_MSBS exceeds the row address width");
   end
   if (WR_CYCLES < 1) begin : g_bad_wr
      $error("WR_CYCLES must be at least 1");
   end

   logic busy, fire, go, clear, prot, prot_row;
   logic start_ev, addr_ev, byte_ev, rd_ev, stop_ev;
   logic [ADDR_W-1:0]              addr_q;
   logic [ROW_W-1:0]               row;
   rcs_pkg::byte_t [ROW_BYTES-1:0] row_data;
   logic [ROW_BYTES-1:0]           mask, wmask;

   assign start_ev = start_i     & ~busy;
   assign addr_ev  = addr_load_i & ~busy;
   assign byte_ev  = byte_vld_i  & ~busy;
   assign rd_ev    = rd_req_i    & ~busy;
   assign stop_ev  = stop_i      & ~busy;

   assign go    = stop_ev & ack_slot_i & (|mask);
   assign clear = (stop_ev & ~go) | fire;
   assign row   = addr_q[ADDR_W-1:COL_W];

   if (PROT_MSBS == 0) begin : g_noprot
      assign prot_row = 1'b0;
   end else begin : g_prot
      assign prot_row = prot & (&row[ROW_W-1 -: PROT_MSBS]);
   end

   assign wmask = prot_row ? '0 : mask;

   rcs_wp_qual u_wp_qual (
      .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .addr_ev(addr_ev),
      .wc(wc_i), .prot_o(prot)
   );

   rcs_row_latch #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_row_latch (
      .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .addr_ev(addr_ev),
      .addr_i(addr_i), .byte_ev(byte_ev), .byte_i(byte_i), .rd_ev(rd_ev),
      .clear(clear), .addr_o(addr_q), .data_o(row_data), .mask_o(mask)
   );

   rcs_prog_timer #(.WR_CYCLES(WR_CYCLES)) u_prog_timer (
      .clk(clk), .rst_n(rst_n), .go(go), .busy_o(busy), .fire_o(fire)
   );

   rcs_array #(.ADDR_W(ADDR_W), .COL_W(COL_W), .ERASED(ERASED)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_en(fire), .wr_row(row),
      .wr_data(row_data), .wr_mask(wmask), .rd_en(rd_ev),
      .rd_addr(addr_q), .rd_data(rd_data_o)
   );

   assign busy_o = busy;
endmodule

// File: rtl/rcs_checker.sv
`timescale 1ns/1ps
module rcs_checker #(
   parameter int unsigned ROW_BYTES = 32,
   parameter int unsigned WR_CYCLES = 1250000
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 stop_i,
   input logic                 ack_slot_i,
   input logic                 rd_req_i,
   input logic                 busy_o,
   input logic [7:0]           rd_data_o,
   input logic                 fire,
   input logic                 prot_row,
   input logic [ROW_BYTES-1:0] wmask
);
   int unsigned bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bcnt <= 0;
      else if (busy_o) bcnt <= bcnt + 1;
      else             bcnt <= 0;
   end

   assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> bcnt == WR_CYCLES + 1);

   assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> bcnt <= WR_CYCLES);

   assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_i && ack_slot_i));

   assert_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !ack_slot_i && !busy_o) |=> !busy_o);

   assert_prot_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && prot_row) |-> wmask == '0);

   assert_fire_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> busy_o ##1 !fire);

   assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_i && !busy_o) |=> $stable(rd_data_o));
endmodule

bind row_commit_store rcs_checker #(.ROW_BYTES(ROW_BYTES), .WR_CYCLES(WR_CYCLES)) u_rcs_checker (
   .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .ack_slot_i(ack_slot_i),
   .rd_req_i(rd_req_i), .busy_o(busy_o), .rd_data_o(rd_data_o),
   .fire(fire), .prot_row(prot_row), .wmask(wmask)
);

// File: tb/row_commit_store_bench.sv
`timescale 1ns/1ps
module row_commit_store_bench;
   localparam int AW = 11;
   localparam int WR = 40;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic start = 0, addr_load = 0, byte_vld = 0, ack_slot = 0, stop = 0, wc = 0, rd_req = 0;
   logic [AW-1:0] addr = '0;
   logic [7:0] din = '0;
   logic busy;
   logic [7:0] rd_data;

   row_commit_store #(.ADDR_W(AW), .WR_CYCLES(WR)) u_row_commit_store (
      .clk(clk), .rst_n(rst_n), .start_i(start), .addr_load_i(addr_load),
      .addr_i(addr), .byte_vld_i(byte_vld), .byte_i(din), .ack_slot_i(ack_slot),
      .stop_i(stop), .wc_i(wc), .rd_req_i(rd_req), .busy_o(busy), .rd_data_o(rd_data)
   );

   typedef struct {logic [7:0] val; int addr; string tag;} exp_t;
   exp_t sb[$];
   logic [7:0] model [DEPTH];
   int checks = 0;
   int fails = 0;
   logic rd_pend = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(posedge clk) rd_pend <= rst_n && rd_req && !busy;
   always @(negedge clk) begin
      exp_t e;
      if (rd_pend) begin
         if (sb.size() == 0) chk(1'b0, "R7", "read with no expectation", rd_data, 0);
         else begin
            e = sb.pop_front();
            chk(rd_data == e.val, e.tag, $sformatf("read @%0h", e.addr), rd_data, e.val);
         end
      end
   end

   task automatic wr(input int a, input int n, input int base, input int wcm,
                     input int endm, input bit probe, input string tag);
      bit prot, commit;
      int cnt;
      logic [7:0] held;
      @(negedge clk) wc = (wcm == 1); start = 1;
      @(negedge clk) start = 0; if (wcm == 2) wc = 1;
      @(negedge clk) if (wcm == 2) wc = 0; addr_load = 1; addr = AW'(a);
      @(negedge clk) addr_load = 0; if (wcm == 3) wc = 1;
      for (int i = 0; i < n; i++) begin
         byte_vld = 1; din = 8'(base + i); ack_slot = 0;
         @(negedge clk) byte_vld = 0; ack_slot = 1;
         @(negedge clk);
      end
      if (n == 0) ack_slot = 1;
      if (endm == 1) ack_slot = 0;
      if (endm == 2) begin
         start = 1; ack_slot = 0;
         @(negedge clk) start = 0;
      end
      stop = 1;
      @(negedge clk) stop = 0; ack_slot = 0; wc = 0;
      commit = (endm == 0) && (n > 0);
      if (commit) begin
         prot = (wcm == 1 || wcm == 2) && ((a >> (AW - 2)) == 3);
         if (!prot)
            for (int i = 0; i < n; i++) model[(a & ~31) | ((a + i) & 31)] = 8'(base + i);
         cnt = 0;
         while (busy && cnt < 1000) begin
            cnt++;
            if (probe && cnt == 1) begin
               held = rd_data; rd_req = 1; start = 1; addr_load = 1; addr = AW'('h300);
            end else if (probe && cnt == 2) begin
               rd_req = 0; start = 0; addr_load = 0;
               chk(rd_data == held, "R8", "rd_data moved while busy", rd_data, held);
            end
            @(negedge clk);
         end
         rd_req = 0; start = 0; addr_load = 0;
         chk(cnt == WR + 1, tag, "busy length", cnt, WR + 1);
      end else begin
         repeat (3) @(negedge clk);
         chk(busy == 1'b0, tag, "busy without commit", busy, 0);
      end
   endtask

   task automatic rd_burst(input int n, input int a, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) rd_req = 1;
         sb.push_back('{model[(a + i) % DEPTH], (a + i) % DEPTH, tag});
      end
      @(negedge clk) rd_req = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic rd(input int a, input int n, input string tag);
      @(negedge clk) start = 1;
      @(negedge clk) start = 0; addr_load = 1; addr = AW'(a);
      @(negedge clk) addr_load = 0; start = 1;
      @(negedge clk) start = 0;
      rd_burst(n, a, tag);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(rd_data == 8'h00, "R1", "rd_data after reset", rd_data, 0);
      rd('h000, 1, "R1");
      rd('h7FF, 1, "R1");
      // R2 single byte
      wr('h123, 1, 'hA5, 0, 0, 0, "R2");
      rd('h122, 3, "R2");
      // R3 page, wrap, last value wins
      wr('h040, 8, 'h10, 0, 0, 0, "R3");
      rd('h040, 10, "R3");
      wr('h07C, 6, 'h30, 0, 0, 0, "R3");
      rd('h060, 32, "R3");
      wr('h0A0, 34, 'h50, 0, 0, 0, "R3");
      rd('h0A0, 3, "R3");
      // R4 discards
      wr('h200, 1, 'h77, 0, 1, 0, "R4");
      wr('h210, 1, 'h66, 0, 2, 0, "R4");
      rd('h200, 1, "R4");
      rd('h210, 1, "R4");
      // R9 address only
      wr('h250, 0, 0, 0, 0, 0, "R9");
      // R5 / R10 protection
      wr('h600, 2, 'hC0, 1, 0, 0, "R10");
      rd('h600, 2, "R5");
      wr('h5FE, 2, 'hD0, 1, 0, 0, "R5");
      rd('h5FE, 2, "R5");
      // R6 window
      wr('h7E0, 1, 'hE1, 2, 0, 0, "R6");
      wr('h7E1, 1, 'hE2, 3, 0, 0, "R6");
      rd('h7E0, 2, "R6");
      // R7 read under wc high, wrap past last address
      wc = 1;
      rd('h7FE, 4, "R7");
      wc = 0;
      // R8 requests ignored during busy; address counter not moved
      wr('h041, 1, 'h99, 0, 0, 1, "R8");
      rd_burst(1, 'h042, "R8");
      chk(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R8", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule